// File: doc/BRIEF.md
# Primitive-to-Quad Setup Unit

This unit sits ahead of a raster drawing stage. The host streams drawing commands into it one vertex per cycle, and the primitive kind on the first beat sets how many vertices follow. Points, lines, triangles and quadrilaterals all leave as one four-vertex quad. The missing vertices are filled by repeating vertices that were received, and no new coordinates are computed. Rectangle-copy commands, given by two corner points, go through the same path and leave marked as a copy.

Before a command is forwarded, its vertices are tested against a programmable window. The window is first clamped to the screen, which spans 0 to a programmable maximum on each axis. A command whose vertices all lie beyond one edge of the clamped window is discarded without output. A command with a coordinate outside the signed 16-bit range, or with an undefined kind code, is also discarded, and it sets a sticky exception flag that the host clears by a register write. Surviving commands are held in a single output register behind a valid/ready handshake.

Top module: `quad_setup`

## Requirements
- R1: After reset, out_valid_o is 0, exc_o is 0 and cmd_ready_o is 1.
- R2: A point (kind 0) takes one beat and emits four copies of that vertex with out_blit_o = 0. Slot i of out_x_o/out_y_o occupies bits [16i+15:16i].
- R3: A line (kind 1, vertices a,b) emits slots a,b,b,a with out_blit_o = 0.
- R4: A triangle (kind 2, vertices a,b,c) emits slots a,b,c,c with out_blit_o = 0.
- R5: A quad (kind 3) takes four beats and emits its vertices in arrival order with out_blit_o = 0.
- R6: A rectangle copy (kind 4, corners a,b) takes two beats and emits slots a,b,b,a with out_blit_o = 1.
- R7: A command is dropped when every vertex has x < xmin, or every vertex has x > xmax, or every vertex has y < ymin, or every vertex has y > ymax, measured against the clamped window. Config addresses: 0 xmin, 1 ymin, 2 xmax, 3 ymax, 4 screen x max, 5 screen y max.
- R8: Window limits are clamped to the screen before testing: minimums to at least 0, and maximums to at most the screen maximums.
- R9: A command with at least one vertex inside on each axis test, including one that straddles a window edge, is forwarded.
- R10: A vertex coordinate outside -32768..32767 on the 18-bit signed input drops the whole command and sets exc_o in the cycle after the last beat. exc_o then stays set.
- R11: Any config write to address 6 clears exc_o.
- R12: While out_valid_o is 1 and out_ready_i is 0, the output fields hold stable and cmd_ready_o is 0.
- R13: A kind code of 5 to 7 is a one-beat command that is dropped and sets exc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_addr_i | input | 3 | Config register address |
| cfg_wdata_i | input | 16 | Config write data, signed |
| cmd_valid_i | input | 1 | Vertex beat valid |
| cmd_ready_o | output | 1 | Vertex beat accepted when high |
| cmd_kind_i | input | 3 | Primitive kind, taken from the first beat |
| cmd_x_i | input | 18 | Vertex x, signed |
| cmd_y_i | input | 18 | Vertex y, signed |
| out_valid_o | output | 1 | Quad command valid |
| out_ready_i | input | 1 | Downstream ready |
| out_blit_o | output | 1 | 1 for a rectangle copy, 0 for a quad draw |
| out_x_o | output | 64 | Four x coordinates, slot 0 in the low bits |
| out_y_o | output | 64 | Four y coordinates, slot 0 in the low bits |
| exc_o | output | 1 | Sticky exception flag |

## Verification
The bench runs each primitive kind with distinct coordinates, so a swapped or missing replication slot shows up as a wrong slot value. It places primitives wholly beyond each of the four window edges, and one straddling an edge. A reject test that used "any vertex" instead of "all vertices" would drop the straddling one, and one that omitted an edge would forward an outside primitive. The window maximum is set past the screen, so a design that skipped clamping would forward geometry drawn off-screen. The bench also sends out-of-range and undefined-kind commands, and it stalls the output. These catch a design that forwards bad commands, forgets the sticky flag, or accepts new beats over an unconsumed result.

// File: rtl/quad_setup_pkg.sv
package quad_setup_pkg;
  localparam int unsigned NV = 4;

  typedef enum logic [2:0] {
    KIND_POINT = 3'd0,
    KIND_LINE  = 3'd1,
    KIND_TRI   = 3'd2,
    KIND_QUAD  = 3'd3,
    KIND_BLIT  = 3'd4
  } prim_kind_e;

  // beats per kind; 0 marks an undefined code
  function automatic logic [2:0] kind_beats(logic [2:0] k);
    case (k)
      KIND_POINT: kind_beats = 3'd1;
      KIND_LINE:  kind_beats = 3'd2;
      KIND_TRI:   kind_beats = 3'd3;
      KIND_QUAD:  kind_beats = 3'd4;
      KIND_BLIT:  kind_beats = 3'd2;
      default:    kind_beats = 3'd0;
    endcase
  endfunction

  // source vertex for output slot s
  function automatic logic [1:0] slot_src(logic [2:0] k, logic [1:0] s);
    case (k)
      KIND_POINT: slot_src = 2'd0;
      KIND_LINE, KIND_BLIT: slot_src = (s == 2'd1 || s == 2'd2) ? 2'd1 : 2'd0;
      KIND_TRI:   slot_src = (s == 2'd3) ? 2'd2 : s;
      default:    slot_src = s;
    endcase
  endfunction
endpackage

// File: rtl/quad_cfg_regs.sv
module quad_cfg_regs #(
  parameter int CW = 16,
  parameter int RST_SCR_XMAX = 1023,
  parameter int RST_SCR_YMAX = 767
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic signed [CW-1:0] wdata_i,
  output logic signed [CW-1:0] eff_xmin_o,
  output logic signed [CW-1:0] eff_ymin_o,
  output logic signed [CW-1:0] eff_xmax_o,
  output logic signed [CW-1:0] eff_ymax_o,
  output logic                 clr_exc_o
);
  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};

  logic signed [CW-1:0] win_xmin_q, win_ymin_q, win_xmax_q, win_ymax_q;
  logic signed [CW-1:0] scr_xmax_q, scr_ymax_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_xmin_q <= '0;
      win_ymin_q <= '0;
      win_xmax_q <= CMAX;
      win_ymax_q <= CMAX;
      scr_xmax_q <= CW'(RST_SCR_XMAX);
      scr_ymax_q <= CW'(RST_SCR_YMAX);
    end else if (we_i) begin
      case (addr_i)
        3'd0: win_xmin_q <= wdata_i;
        3'd1: win_ymin_q <= wdata_i;
        3'd2: win_xmax_q <= wdata_i;
        3'd3: win_ymax_q <= wdata_i;
        3'd4: scr_xmax_q <= wdata_i;
        3'd5: scr_ymax_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // clamp window to screen [0, scr_max]
  always_comb begin
    eff_xmin_o = (win_xmin_q < 0) ? '0 : win_xmin_q;
    eff_ymin_o = (win_ymin_q < 0) ? '0 : win_ymin_q;
    eff_xmax_o = (win_xmax_q > scr_xmax_q) ? scr_xmax_q : win_xmax_q;
    eff_ymax_o = (win_ymax_q > scr_ymax_q) ? scr_ymax_q : win_ymax_q;
  end

  assign clr_exc_o = we_i && (addr_i == 3'd6);

  AST_CLAMP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_xmax_o <= scr_xmax_q) && (eff_ymax_o <= scr_ymax_q)); // R8
endmodule

// File: rtl/quad_gather.sv
module quad_gather
  import quad_setup_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 18
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_i,
  input  logic [2:0]                  kind_i,
  input  logic signed [IW-1:0]        x_i,
  input  logic signed [IW-1:0]        y_i,
  output logic                        done_o,
  output logic                        exc_o,
  output logic                        blit_o,
  output logic [NV-1:0][CW-1:0]       qx_o,
  output logic [NV-1:0][CW-1:0]       qy_o
);
  localparam logic signed [IW-1:0] LO = -(IW'(1) <<< (CW-1));
  localparam logic signed [IW-1:0] HI = (IW'(1) <<< (CW-1)) - 1;

  logic [1:0]              cnt_q;
  logic [2:0]              kind_q;
  logic                    exc_q;
  logic [NV-1:0][CW-1:0]   vx_q, vy_q;
  logic [NV-1:0][CW-1:0]   vx_c, vy_c;
  logic [2:0]              kind_c, nbeats;
  logic                    in_bad, last;

  assign kind_c = (cnt_q == 2'd0) ? kind_i : kind_q;
  assign nbeats = kind_beats(kind_c);
  assign in_bad = (x_i < LO) || (x_i > HI) || (y_i < LO) || (y_i > HI);
  assign last   = (nbeats == 3'd0) || ({1'b0, cnt_q} + 3'd1 == nbeats);

  always_comb begin
    vx_c = vx_q;
    vy_c = vy_q;
    vx_c[cnt_q] = x_i[CW-1:0];
    vy_c[cnt_q] = y_i[CW-1:0];
  end

  for (genvar s = 0; s < NV; s++) begin : g_slot
    assign qx_o[s] = vx_c[slot_src(kind_c, 2'(s))];
    assign qy_o[s] = vy_c[slot_src(kind_c, 2'(s))];
  end

  assign done_o = acc_i && last;
  assign exc_o  = exc_q || in_bad || (nbeats == 3'd0);
  assign blit_o = (kind_c == KIND_BLIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= '0;
      exc_q  <= 1'b0;
      vx_q   <= '0;
      vy_q   <= '0;
    end else if (acc_i) begin
      vx_q <= vx_c;
      vy_q <= vy_c;
      if (last) begin
        cnt_q <= '0;
        exc_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 2'd1;
        kind_q <= kind_c;
        exc_q  <= exc_q || in_bad;
      end
    end
  end

  AST_CNT_IN_PRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 2'd0) |-> ({1'b0, cnt_q} < kind_beats(kind_q))); // R5
endmodule

// File: rtl/quad_reject.sv
module quad_reject
  import quad_setup_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [NV-1:0][CW-1:0] qx_i,
  input  logic [NV-1:0][CW-1:0] qy_i,
  input  logic signed [CW-1:0]  xmin_i,
  input  logic signed [CW-1:0]  ymin_i,
  input  logic signed [CW-1:0]  xmax_i,
  input  logic signed [CW-1:0]  ymax_i,
  output logic                  reject_o
);
  logic [NV-1:0] lt_x, gt_x, lt_y, gt_y;

  for (genvar v = 0; v < NV; v++) begin : g_vtx
    assign lt_x[v] = $signed(qx_i[v]) < xmin_i;
    assign gt_x[v] = $signed(qx_i[v]) > xmax_i;
    assign lt_y[v] = $signed(qy_i[v]) < ymin_i;
    assign gt_y[v] = $signed(qy_i[v]) > ymax_i;
  end

  assign reject_o = (&lt_x) | (&gt_x) | (&lt_y) | (&gt_y);
endmodule

// File: rtl/quad_setup.sv
module quad_setup
  import quad_setup_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 18,
  parameter int RST_SCR_XMAX = 1023,
  parameter int RST_SCR_YMAX = 767
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [CW-1:0]    cfg_wdata_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_kind_i,
  input  logic [IW-1:0]    cmd_x_i,
  input  logic [IW-1:0]    cmd_y_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_blit_o,
  output logic [NV*CW-1:0] out_x_o,
  output logic [NV*CW-1:0] out_y_o,
  output logic             exc_o
);
  logic signed [CW-1:0]  xmin, ymin, xmax, ymax;
  logic                  clr_exc, acc, done, g_exc, g_blit, reject, load;
  logic [NV-1:0][CW-1:0] qx, qy, ox_q, oy_q;
  logic                  valid_q, blit_q, exc_q;

  quad_cfg_regs #(.CW(CW), .RST_SCR_XMAX(RST_SCR_XMAX), .RST_SCR_YMAX(RST_SCR_YMAX)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .eff_xmin_o(xmin), .eff_ymin_o(ymin), .eff_xmax_o(xmax), .eff_ymax_o(ymax),
    .clr_exc_o(clr_exc)
  );

  assign cmd_ready_o = !valid_q || out_ready_i;
  assign acc         = cmd_valid_i && cmd_ready_o;

  quad_gather #(.CW(CW), .IW(IW)) u_gather (
    .clk_i, .rst_ni, .acc_i(acc), .kind_i(cmd_kind_i),
    .x_i(cmd_x_i), .y_i(cmd_y_i),
    .done_o(done), .exc_o(g_exc), .blit_o(g_blit), .qx_o(qx), .qy_o(qy)
  );

  quad_reject #(.CW(CW)) u_reject (
    .qx_i(qx), .qy_i(qy),
    .xmin_i(xmin), .ymin_i(ymin), .xmax_i(xmax), .ymax_i(ymax),
    .reject_o(reject)
  );

  assign load = done && !g_exc && !reject;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      blit_q  <= 1'b0;
      ox_q    <= '0;
      oy_q    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      blit_q  <= g_blit;
      ox_q    <= qx;
      oy_q    <= qy;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              exc_q <= 1'b0;
    else if (done && g_exc)   exc_q <= 1'b1;
    else if (clr_exc)         exc_q <= 1'b0;
  end

  assign out_valid_o = valid_q;
  assign out_blit_o  = blit_q;
  assign out_x_o     = ox_q;
  assign out_y_o     = oy_q;
  assign exc_o       = exc_q;

  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_x_o) && $stable(out_y_o) && $stable(out_blit_o)); // R12
  AST_EXC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o && !clr_exc |=> exc_o); // R10
  AST_EXC_NO_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && g_exc |=> !out_valid_o && exc_o); // R10
  AST_BLIT_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_blit_o |-> ox_q[1] == ox_q[2] && ox_q[0] == ox_q[3] && oy_q[1] == oy_q[2]); // R6
endmodule

// File: tb/quad_setup_tb.sv
`timescale 1ns/1ps
module quad_setup_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cmd_valid = 1'b0, out_ready = 1'b1;
  logic [2:0]  cmd_kind = '0;
  logic [17:0] cmd_x = '0, cmd_y = '0;
  logic        cmd_ready, out_valid, out_blit, exc;
  logic [63:0] out_x, out_y;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  quad_setup dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_kind_i(cmd_kind),
    .cmd_x_i(cmd_x), .cmd_y_i(cmd_y),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_blit_o(out_blit),
    .out_x_o(out_x), .out_y_o(out_y), .exc_o(exc)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk(input int a, input int b, input int c, input int d);
    pk = {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(input int k, input int x, input int y);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 3'(k); cmd_x = 18'(x); cmd_y = 18'(y);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // expect a forwarded command at the current negedge
  task automatic expect_out(input string req, input bit blit, input logic [63:0] ex, input logic [63:0] ey);
    chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    chk(out_blit == blit, req, 64'(out_blit), 64'(blit));
    chk(out_x == ex, req, out_x, ex);
    chk(out_y == ey, req, out_y, ey);
  endtask

  task automatic expect_none(input string req);
    chk(out_valid == 1'b0, req, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    chk(exc == 1'b0, "R1", 64'(exc), 64'd0);
    chk(cmd_ready == 1'b1, "R1", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_point;
    beat(0, 200, 120);
    expect_out("R2", 1'b0, pk(200, 200, 200, 200), pk(120, 120, 120, 120));
  endtask

  task automatic t_line;
    beat(1, 150, 60); beat(1, 500, 300);
    expect_out("R3", 1'b0, pk(150, 500, 500, 150), pk(60, 300, 300, 60));
  endtask

  task automatic t_tri;
    beat(2, 110, 70); beat(2, 220, 90); beat(2, 330, 210);
    expect_out("R4", 1'b0, pk(110, 220, 330, 330), pk(70, 90, 210, 210));
  endtask

  task automatic t_quad;
    beat(3, 120, 80); beat(3, 240, 81); beat(3, 260, 190); beat(3, 130, 170);
    expect_out("R5", 1'b0, pk(120, 240, 260, 130), pk(80, 81, 190, 170));
  endtask

  task automatic t_blit;
    beat(4, 140, 100); beat(4, 380, 260);
    expect_out("R6", 1'b1, pk(140, 380, 380, 140), pk(100, 260, 260, 100));
  endtask

  task automatic t_reject;
    beat(1, 10, 60); beat(1, 99, 300);   expect_none("R7 left");
    beat(1, 601, 60); beat(1, 900, 300); expect_none("R7 right");
    beat(2, 150, 10); beat(2, 300, 20); beat(2, 400, 49); expect_none("R7 top");
    beat(0, 300, 401);                   expect_none("R7 bottom");
  endtask

  task automatic t_straddle;
    beat(1, 20, 20); beat(1, 200, 200);
    expect_out("R9", 1'b0, pk(20, 200, 200, 20), pk(20, 200, 200, 20));
  endtask

  task automatic t_clamp;
    cfg_wr(2, 2000);
    beat(1, 1100, 100); beat(1, 1500, 200); expect_none("R8 beyond screen");
    beat(0, 900, 100);
    expect_out("R8 inside screen", 1'b0, pk(900, 900, 900, 900), pk(100, 100, 100, 100));
    cfg_wr(2, 600);
  endtask

  task automatic t_exc;
    beat(1, 200, 100); beat(1, 32768, 100);
    expect_none("R10 drop");
    chk(exc == 1'b1, "R10 set", 64'(exc), 64'd1);
    beat(0, 300, 200);
    expect_out("R10 next ok", 1'b0, pk(300, 300, 300, 300), pk(200, 200, 200, 200));
    chk(exc == 1'b1, "R10 sticky", 64'(exc), 64'd1);
    cfg_wr(6, 0);
    chk(exc == 1'b0, "R11 clear", 64'(exc), 64'd0);
    beat(0, 300, -32769); expect_none("R10 low y");
    chk(exc == 1'b1, "R10 low y", 64'(exc), 64'd1);
    cfg_wr(6, 0);
  endtask

  task automatic t_bad_kind;
    beat(6, 200, 200);
    expect_none("R13");
    chk(exc == 1'b1, "R13", 64'(exc), 64'd1);
    beat(0, 210, 220);
    expect_out("R13 one beat", 1'b0, pk(210, 210, 210, 210), pk(220, 220, 220, 220));
    cfg_wr(6, 0);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    beat(0, 250, 150);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_out("R12 hold", 1'b0, pk(250, 250, 250, 250), pk(150, 150, 150, 150));
      chk(cmd_ready == 1'b0, "R12 ready", 64'(cmd_ready), 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    expect_none("R12 release");
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_wr(0, 100); cfg_wr(1, 50); cfg_wr(2, 600); cfg_wr(3, 400);
    t_point();
    t_line();
    t_tri();
    t_quad();
    t_blit();
    t_reject();
    t_straddle();
    t_clamp();
    t_exc();
    t_bad_kind();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule